// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block watches the command bus that a memory controller drives towards a four-bank DDR2-style SDRAM. On every rising clock edge it decodes the command from the chip-select, row-strobe, column-strobe and write-enable pins and the bank address. It keeps a record for each bank of whether the bank is idle or holds an open row, and which row that is. It also measures the distances between commands against five programmable row-timing limits. All limits are given in clock cycles as run-time inputs.

Each command slot produces a registered verdict one clock later. When the command was legal, no violation is reported and the bank state is updated. When it was illegal, a single-cycle violation pulse appears with an error code. The illegal command is then discarded: it changes no state and issues nothing.

Reads and writes may be posted early. A read or write that has been accepted is issued internally after a programmable additive latency. The block emits a one-cycle pulse, carrying the bank number and the write flag, at the moment of that internal issue. The controller or a monitor uses this block to keep its own scheduling honest, or to flag broken command streams.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are decoded with chip-select low from (row-strobe, column-strobe, write-enable) as follows: activate 0,1,1; read 1,0,1; write 1,0,0; precharge 0,1,0; no-op 1,1,1. A slot with chip-select high is a deselect. A deselect changes no state and raises no violation.
- R2: An activate that meets every limit, sent to an idle bank, sets that bank's open flag. It also stores the row: the full 14-bit address when `cfg_row13`=0, or the address with bit 13 forced to 0 when `cfg_row13`=1. Both are visible in the cycle after the command.
- R3: A read or write to an idle bank raises a violation with code 5.
- R4: An activate to a bank that is already open raises a violation with code 1.
- R5: An activate that comes fewer than `cfg_trc` cycles after the previous activate to the same bank raises code 2.
- R6: An activate that comes fewer than `cfg_trp` cycles after the precharge that closed that bank raises code 3.
- R7: An activate that comes fewer than `cfg_trrd` cycles after an activate to a different bank raises code 4.
- R8: Let d be the distance in cycles from a bank's activate to a read or write of that bank. If d + `cfg_al` < `cfg_trcd`, the read or write raises code 6.
- R9: A precharge to an open bank that comes fewer than `cfg_tras` cycles after its activate raises code 7. A legal precharge clears the open flag. A precharge to an idle bank is legal and has no effect.
- R10: A legal read or write issued in cycle t produces `int_rw_valid` for exactly one cycle, in cycle t+1+`cfg_al`, with the bank number and the write flag (1 for write).
- R11: When an activate breaks several limits, only one code is reported, checked in this order: code 1, then 2, 3, 4. When a read or write breaks several limits, code 5 is checked before code 6. A violation is a single-cycle pulse with a nonzero code, and the code is 0 whenever there is no violation. A command that violates changes no bank state and issues no internal read or write.
- R12: After reset, every bank is idle and there is no violation or internal issue. All timers start saturated, so the first activate to any bank is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_bank | input | 2 | Bank address |
| cmd_addr | input | 14 | Row address on activate |
| cfg_row13 | input | 1 | 1: row is 13 bits wide |
| cfg_trcd | input | 5 | Activate-to-read/write limit |
| cfg_trrd | input | 5 | Activate-to-activate limit, different banks |
| cfg_tras | input | 5 | Activate-to-precharge limit |
| cfg_trp | input | 5 | Precharge-to-activate limit |
| cfg_trc | input | 5 | Activate-to-activate limit, same bank |
| cfg_al | input | 3 | Additive latency, 0 to 5 |
| bank_open | output | 4 | Open flag for each bank |
| open_row | output | 56 | Stored row for each bank, bank b in bits [14b+13:14b] |
| viol | output | 1 | Violation pulse |
| viol_code | output | 3 | Error code, 0 when there is no violation |
| int_rw_valid | output | 1 | Internal read/write issue pulse |
| int_rw_write | output | 1 | Issued command is a write |
| int_rw_bank | output | 2 | Bank of the issued command |

## Verification
The bench builds the block with its defaults: four banks, 14-bit rows, 5-bit timers and additive latency up to 5. It programs small limits (tRCD 4, tRRD 3, tRAS 6, tRP 3, tRC 10) so that each limit sits only a few cycles from an activate. That makes full sweeps practical. The bench covers every pair of additive latency and activate-to-read gap from 1 to 6, gaps on both sides of tRAS and tRRD, and a grid of precharge placements by reopen gaps. This grid reaches both codes 2 and 3 and the priority between them. Expected codes and issue cycles come from the gap arithmetic alone.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ACT_OPEN = 3'd1,
    ERR_TRC      = 3'd2,
    ERR_TRP      = 3'd3,
    ERR_TRRD     = 3'd4,
    ERR_RW_IDLE  = 3'd5,
    ERR_TRCD     = 3'd6,
    ERR_TRAS     = 3'd7
  } err_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sbt_sat_cnt.sv
module sbt_sat_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr)               cnt_d = W'(1);
    else if (cnt == CMAX)  cnt_d = cnt;
    else                   cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= CMAX;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/sbt_bank_state.sv
module sbt_bank_state #(
  parameter int ROW_W = 14,
  parameter int TW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic [TW-1:0]    since_act,
  output logic [TW-1:0]    since_pre
);

  logic open_d;

  always_comb begin
    open_d = is_open;
    if (act_en)      open_d = 1'b1;
    else if (pre_en) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) is_open <= 1'b0;
    else        is_open <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (act_en) row_q <= row_in;
  end

  sbt_sat_cnt #(.W(TW)) u_act_cnt (
    .clk(clk), .rst_n(rst_n), .clr(act_en), .cnt(since_act)
  );

  sbt_sat_cnt #(.W(TW)) u_pre_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pre_en), .cnt(since_pre)
  );

endmodule

// File: rtl/sbt_posted_cas.sv
module sbt_posted_cas #(
  parameter int BW     = 2,
  parameter int ALW    = 3,
  parameter int MAX_AL = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           push_wr,
  input  logic [BW-1:0]  push_bank,
  input  logic [ALW-1:0] al,
  output logic           out_valid,
  output logic           out_wr,
  output logic [BW-1:0]  out_bank
);

  localparam int DEPTH = MAX_AL + 1;

  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [DEPTH-1:0]         wr_q,  wr_d;
  logic [DEPTH-1:0][BW-1:0] bk_q,  bk_d;
  logic [ALW-1:0]           al_eff;

  assign al_eff = (al > ALW'(MAX_AL)) ? ALW'(MAX_AL) : al;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i < DEPTH - 1) begin
        vld_d[i] = vld_q[i+1];
        wr_d[i]  = wr_q[i+1];
        bk_d[i]  = bk_q[i+1];
      end else begin
        vld_d[i] = 1'b0;
        wr_d[i]  = 1'b0;
        bk_d[i]  = '0;
      end
      if (push && (al_eff == ALW'(i))) begin
        vld_d[i] = 1'b1;
        wr_d[i]  = push_wr;
        bk_d[i]  = push_bank;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wr_q  <= '0;
      bk_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wr_q  <= wr_d;
      bk_q  <= bk_d;
    end
  end

  assign out_valid = vld_q[0];
  assign out_wr    = wr_q[0];
  assign out_bank  = bk_q[0];

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ROW_W     = 14,
  parameter  int TW        = 5,
  parameter  int ALW       = 3,
  parameter  int MAX_AL    = 5,
  localparam int BW        = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_cs_n,
  input  logic                       cmd_ras_n,
  input  logic                       cmd_cas_n,
  input  logic                       cmd_we_n,
  input  logic [BW-1:0]              cmd_bank,
  input  logic [ROW_W-1:0]           cmd_addr,
  input  logic                       cfg_row13,
  input  logic [TW-1:0]              cfg_trcd,
  input  logic [TW-1:0]              cfg_trrd,
  input  logic [TW-1:0]              cfg_tras,
  input  logic [TW-1:0]              cfg_trp,
  input  logic [TW-1:0]              cfg_trc,
  input  logic [ALW-1:0]             cfg_al,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic                       viol,
  output logic [2:0]                 viol_code,
  output logic                       int_rw_valid,
  output logic                       int_rw_write,
  output logic [BW-1:0]              int_rw_bank
);

  localparam int SW = TW + 1;

  cmd_e           cmd;
  err_e           err;
  logic           ok;
  logic           act_acc, pre_acc, rw_acc;
  logic [TW-1:0]  sact [NUM_BANKS];
  logic [TW-1:0]  spre [NUM_BANKS];
  logic [TW-1:0]  since_any_act;
  logic [BW-1:0]  last_act_bank;
  logic [ROW_W-1:0] row_in;
  logic [SW-1:0]  rcd_dist;
  logic           sel_open;

  sbt_cmd_decode u_dec (
    .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .cmd(cmd)
  );

  // Row width selection: narrow organisation drops the top row bit
  always_comb begin
    row_in = cmd_addr;
    if (cfg_row13) row_in[ROW_W-1] = 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit = (cmd_bank == BW'(g));
      sbt_bank_state #(.ROW_W(ROW_W), .TW(TW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (act_acc && hit),
        .pre_en    (pre_acc && hit),
        .row_in    (row_in),
        .is_open   (bank_open[g]),
        .row_q     (open_row[g*ROW_W +: ROW_W]),
        .since_act (sact[g]),
        .since_pre (spre[g])
      );
    end
  endgenerate

  sbt_sat_cnt #(.W(TW)) u_rrd_cnt (
    .clk(clk), .rst_n(rst_n), .clr(act_acc), .cnt(since_any_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_act_bank <= '0;
    else if (act_acc) last_act_bank <= cmd_bank;
  end

  assign sel_open = bank_open[cmd_bank];
  assign rcd_dist = {1'b0, sact[cmd_bank]} + SW'(cfg_al);

  // Legality check with fixed priority per command
  always_comb begin
    err = ERR_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (sel_open)                        err = ERR_ACT_OPEN;
        else if (sact[cmd_bank] < cfg_trc)   err = ERR_TRC;
        else if (spre[cmd_bank] < cfg_trp)   err = ERR_TRP;
        else if ((last_act_bank != cmd_bank) &&
                 (since_any_act < cfg_trrd)) err = ERR_TRRD;
      end
      CMD_RD, CMD_WR: begin
        if (!sel_open)                       err = ERR_RW_IDLE;
        else if (rcd_dist < SW'(cfg_trcd))   err = ERR_TRCD;
      end
      CMD_PRE: begin
        if (sel_open && (sact[cmd_bank] < cfg_tras)) err = ERR_TRAS;
      end
      default: err = ERR_NONE;
    endcase
  end

  assign ok      = (err == ERR_NONE);
  assign act_acc = ok && (cmd == CMD_ACT);
  assign pre_acc = ok && (cmd == CMD_PRE) && sel_open;
  assign rw_acc  = ok && ((cmd == CMD_RD) || (cmd == CMD_WR));

  sbt_posted_cas #(.BW(BW), .ALW(ALW), .MAX_AL(MAX_AL)) u_posted (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rw_acc),
    .push_wr   (cmd == CMD_WR),
    .push_bank (cmd_bank),
    .al        (cfg_al),
    .out_valid (int_rw_valid),
    .out_wr    (int_rw_write),
    .out_bank  (int_rw_bank)
  );

  logic       viol_d;
  logic [2:0] code_d;

  always_comb begin
    viol_d = !ok;
    code_d = err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= 3'd0;
    end else begin
      viol      <= viol_d;
      viol_code <= code_d;
    end
  end

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter  int NUM_BANKS = 4,
  localparam int BW        = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_cs_n,
  input logic                 cmd_ras_n,
  input logic                 cmd_cas_n,
  input logic                 cmd_we_n,
  input logic [BW-1:0]        cmd_bank,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 viol,
  input logic [2:0]           viol_code
);

  logic pin_act, pin_rw, pin_pre;
  assign pin_act = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
  assign pin_rw  = !cmd_cs_n &&  cmd_ras_n && !cmd_cas_n;
  assign pin_pre = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs_n |=> !viol); // R1

  AST_RW_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rw && !bank_open[cmd_bank]) |=> (viol && viol_code == 3'd5)); // R3

  AST_REOPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_act && bank_open[cmd_bank]) |=> (viol && viol_code == 3'd1)); // R4

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0)); // R11

  AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_code == 3'd0)); // R11

  AST_VIOL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $stable(bank_open)); // R11

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
      AST_OPEN_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open[g]) |-> $past(pin_act && cmd_bank == BW'(g))); // R2
      AST_CLOSE_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_open[g]) |-> $past(pin_pre && cmd_bank == BW'(g))); // R9
    end
  endgenerate

endmodule

bind sdram_bank_tracker sbt_checker #(.NUM_BANKS(NUM_BANKS)) u_sbt_checker (.*);

// File: tb/sdram_bank_tracker_bench.sv
`timescale 1ns/1ps
module sdram_bank_tracker_bench;

  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_DES = 4'b1000;
  localparam int TRCD = 4, TRRD = 3, TRAS = 6, TRP = 3, TRC = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  bank;
  logic [13:0] addr;
  logic        row13;
  logic [2:0]  al;
  logic [3:0]  bank_open;
  logic [55:0] open_row;
  logic        viol;
  logic [2:0]  viol_code;
  logic        iv, iw;
  logic [1:0]  ib;

  logic        s_viol, s_iv, s_iw;
  logic [2:0]  s_code;
  logic [3:0]  s_open;
  logic [55:0] s_row;
  logic [1:0]  s_ib;

  int n_total = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_bank(bank), .cmd_addr(addr), .cfg_row13(row13),
    .cfg_trcd(5'(TRCD)), .cfg_trrd(5'(TRRD)), .cfg_tras(5'(TRAS)),
    .cfg_trp(5'(TRP)), .cfg_trc(5'(TRC)), .cfg_al(al),
    .bank_open(bank_open), .open_row(open_row), .viol(viol),
    .viol_code(viol_code), .int_rw_valid(iv), .int_rw_write(iw),
    .int_rw_bank(ib)
  );

  task automatic chk(input logic cond, input string req, input int act, input int exp);
    n_total++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample();
    s_viol = viol; s_code = viol_code; s_open = bank_open; s_row = open_row;
    s_iv = iv; s_iw = iw; s_ib = ib;
  endtask

  task automatic step(input logic [3:0] p, input logic [1:0] b, input logic [13:0] a);
    {cs_n, ras_n, cas_n, we_n} = p;
    bank = b;
    addr = a;
    @(negedge clk);
    sample();
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(P_NOP, 2'd0, 14'd0);
  endtask

  task automatic do_reset();
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    bank = 2'd0; addr = 14'd0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sample();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    row13 = 1'b0;
    al    = 3'd0;
    do_reset();

    // R12: reset state
    chk(s_open == 4'b0, "R12 open flags", int'(s_open), 0);
    chk(!s_viol && s_code == 3'd0, "R12 viol", int'(s_viol), 0);
    chk(!s_iv, "R12 issue", int'(s_iv), 0);
    step(P_ACT, 2'd3, 14'h0123);
    chk(!s_viol, "R12 first activate legal", int'(s_code), 0);
    chk(s_open == 4'b1000, "R2 open flag", int'(s_open), 8);
    chk(s_row[42 +: 14] == 14'h0123, "R2 stored row", int'(s_row[42 +: 14]), 'h123);

    // R1: deselect and no-op leave state untouched
    step(P_DES, 2'd0, 14'd0);
    chk(!s_viol && s_open == 4'b1000, "R1 deselect", int'(s_open), 8);
    step(P_NOP, 2'd3, 14'd0);
    chk(!s_viol && s_open == 4'b1000, "R1 nop", int'(s_open), 8);

    // R3 and R9: commands to idle banks
    do_reset();
    step(P_RD, 2'd2, 14'd0);
    chk(s_viol && s_code == 3'd5, "R3 read idle", int'(s_code), 5);
    step(P_WR, 2'd1, 14'd0);
    chk(s_viol && s_code == 3'd5, "R3 write idle", int'(s_code), 5);
    nops(6);
    chk(!s_iv, "R11 no issue after violation", int'(s_iv), 0);
    step(P_PRE, 2'd1, 14'd0);
    chk(!s_viol && s_open == 4'b0, "R9 precharge idle ignored", int'(s_viol), 0);

    // R8 / R10 sweep: additive latency by activate-to-column gap
    for (int a = 0; a <= 5; a++) begin
      for (int d = 1; d <= 6; d++) begin
        logic [1:0] b;
        logic       wr, legal;
        b = 2'((a + d) % 4);
        wr = d[0];
        legal = ((d + a) >= TRCD);
        do_reset();
        al = 3'(a);
        step(P_ACT, b, 14'(a * 8 + d));
        chk(s_open[b], "R2 open after activate", int'(s_open), 1 << b);
        if (d > 1) nops(d - 1);
        step(wr ? P_WR : P_RD, b, 14'd0);
        chk(s_viol == !legal, "R8 trcd verdict", int'(s_viol), int'(!legal));
        if (!legal) chk(s_code == 3'd6, "R8 trcd code", int'(s_code), 6);
        for (int j = 0; j <= 6; j++) begin
          logic expv;
          if (j > 0) step(P_NOP, 2'd0, 14'd0);
          expv = legal && (j == a);
          chk(s_iv == expv, "R10 issue timing", int'(s_iv), int'(expv));
          if (expv) begin
            chk(s_ib == b, "R10 issue bank", int'(s_ib), int'(b));
            chk(s_iw == wr, "R10 issue write flag", int'(s_iw), int'(wr));
          end
        end
      end
    end
    al = 3'd0;

    // R9 sweep: tRAS
    for (int d = 1; d <= 8; d++) begin
      logic [1:0] b;
      logic bad;
      b = 2'(d % 4);
      bad = (d < TRAS);
      do_reset();
      step(P_ACT, b, 14'd5);
      if (d > 1) nops(d - 1);
      step(P_PRE, b, 14'd0);
      chk(s_viol == bad, "R9 tras verdict", int'(s_viol), int'(bad));
      if (bad) chk(s_code == 3'd7, "R9 tras code", int'(s_code), 7);
      chk(s_open[b] == bad, "R9 open after precharge", int'(s_open[b]), int'(bad));
    end

    // R5 / R6 / R11 grid: precharge placement by reopen gap
    for (int pi = 0; pi < 3; pi++) begin
      for (int g = 1; g <= 5; g++) begin
        int p, expc;
        p = 6 + 2 * pi;
        expc = ((p + g) < TRC) ? 2 : ((g < TRP) ? 3 : 0);
        do_reset();
        step(P_ACT, 2'd2, 14'd9);
        nops(p - 1);
        step(P_PRE, 2'd2, 14'd0);
        chk(!s_viol && !s_open[2], "R9 legal precharge closes", int'(s_open[2]), 0);
        if (g > 1) nops(g - 1);
        step(P_ACT, 2'd2, 14'd10);
        chk(int'(s_code) == expc, expc == 3 ? "R6 trp code" : "R5 trc code", int'(s_code), expc);
        chk(s_viol == (expc != 0), "R11 viol matches code", int'(s_viol), int'(expc != 0));
        chk(s_open[2] == (expc == 0), "R11 state only on legal", int'(s_open[2]), int'(expc == 0));
      end
    end

    // R7 sweep: tRRD between different banks
    for (int g = 1; g <= 5; g++) begin
      logic bad;
      bad = (g < TRRD);
      do_reset();
      step(P_ACT, 2'd0, 14'h0AB);
      if (g > 1) nops(g - 1);
      step(P_ACT, 2'd1, 14'h011);
      chk(s_viol == bad, "R7 trrd verdict", int'(s_viol), int'(bad));
      if (bad) chk(s_code == 3'd4, "R7 trrd code", int'(s_code), 4);
      chk(s_open[1] == !bad, "R7 open on legal", int'(s_open[1]), int'(!bad));
    end

    // R4 / R11: reopen of an open bank keeps its row
    do_reset();
    step(P_ACT, 2'd0, 14'h0AB);
    step(P_ACT, 2'd0, 14'h155);
    chk(s_viol && s_code == 3'd1, "R4 reopen code", int'(s_code), 1);
    chk(s_row[0 +: 14] == 14'h0AB, "R11 row unchanged", int'(s_row[0 +: 14]), 'h0AB);

    // R2: row width selection
    do_reset();
    row13 = 1'b1;
    step(P_ACT, 2'd1, 14'h3FFF);
    chk(s_row[14 +: 14] == 14'h1FFF, "R2 narrow row", int'(s_row[14 +: 14]), 'h1FFF);
    row13 = 1'b0;
    nops(TRRD);
    step(P_ACT, 2'd2, 14'h3FFF);
    chk(s_row[28 +: 14] == 14'h3FFF, "R2 wide row", int'(s_row[28 +: 14]), 'h3FFF);

    finish_run();
  end

endmodule